// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block generates the timing strobes for a raster display from one pixel clock. A horizontal counter counts clocks within a line. A vertical counter counts lines within a frame. Comparisons against a set of programmed interval values produce these signals:

- horizontal and vertical blank
- horizontal and vertical sync
- composite blank (the OR of the two blanks)
- composite sync (horizontal sync inverted during vertical sync)
- a vertical interrupt window
- horizontal and vertical gating windows, whose AND forms a cursor window

Four output pins carry a subset of these signals. A 3-bit routing code in a control word selects the subset, and each pin has its own polarity bit.

Software loads the control word and the interval registers through a simple synchronous write port. The interval values are staged and take effect together at the next frame boundary, so no frame mixes old and new settings. The control word takes effect on the next clock. Bits in the control word also stop the counters and select a counter test mode, in which the line counter steps on every clock.

Top module: `raster_sync_gen`

## Requirements
- R1: After reset both counters hold 1, the routing code is 000, all pins are active low, the counters run and test mode is off. The default interval set is: line length 16, horizontal sync 2..4, horizontal blank 6, frame length 8, vertical sync 1..2, vertical blank 3, interrupt 1..2, all gating bounds 0. The reset value of `sync_pins` is 4'b1110.
- R2: The horizontal count runs from 1. When the count is at or above the line length, it reloads to 1 and the line count advances. The line count likewise reloads to 1 after reaching the frame length.
- R3: A window with bounds (lo, hi) is active for counts lo+1 through hi. Horizontal blank uses (0, blank width) and horizontal sync uses (front porch, sync end), both on the clock count. Vertical blank and sync use the same rule on the line count.
- R4: A write to the line-length register has bit 0 forced to 0, so the line length is always even.
- R5: Pin routing uses pins p3,p2,p1,p0, where `sync_pins[k]` is pk. Control bit 0 selects vertical blank over composite blank on p0. Bit 1 selects vertical sync over composite sync on p1, and horizontal sync on p3. On p2, bit 0 selects horizontal blank; otherwise bit 2 selects the cursor over the horizontal gate. On p3, when bit 1 is clear, bit 2 selects the vertical interrupt over the vertical gate.
- R6: Control bits 5, 6, 7 and 8 set the polarity of p0, p1, p2 and p3: 1 means active high and 0 means active low.
- R7: The vertical interrupt is the line-count window (activate, deactivate). The cursor is the AND of the clock-count gate window and the line-count gate window.
- R8: The port addresses are:
  - 0: control word
  - 1 to 4: line length, horizontal front porch, horizontal sync end, horizontal blank width
  - 5 to 8: the same four vertical values
  - 9 and 10: interrupt activate and deactivate
  - 11 and 12: horizontal gate bounds
  - 13 and 14: vertical gate bounds

  Address 15 is discarded. Interval writes take effect only on the clock that ends a frame. The control word applies from the next clock.
- R9: With control bit 10 clear, both counters hold their values and the timing outputs stay unchanged.
- R10: With control bit 11 set, the line count advances on every running clock. It still reloads at the frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| sync_pins | output | 4 | Routed and polarity-adjusted timing pins |

## Verification
The hardest case to reach is a staged interval write that lands mid-frame, especially one that shortens the line below the current count. The design must keep the old settings until the frame ends and then reload cleanly. The stimulus reprograms the line length while the counters run at arbitrary positions. It leaves the comparison to a behavioural model that tracks its own staged and active copies, checks the pins on every clock, and times the new line length by measuring the blank pulse period. All eight routing codes run under three polarity patterns, followed by stalled-clock and test-mode phases.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int NREG    = 15;
  localparam int RI_CTRL = 0;
  localparam int RI_HTOT = 1;
  localparam int RI_HFP  = 2;
  localparam int RI_HSE  = 3;
  localparam int RI_HBW  = 4;
  localparam int RI_VTOT = 5;
  localparam int RI_VFP  = 6;
  localparam int RI_VSE  = 7;
  localparam int RI_VBW  = 8;
  localparam int RI_VION = 9;
  localparam int RI_VIOF = 10;
  localparam int RI_CHLO = 11;
  localparam int RI_CHHI = 12;
  localparam int RI_CVLO = 13;
  localparam int RI_CVHI = 14;

  // control word bit positions
  localparam int CB_MAP  = 0;
  localparam int CB_POL  = 5;
  localparam int CB_RUN  = 10;
  localparam int CB_TEST = 11;

  typedef struct packed {
    logic hblank;
    logic hsync;
    logic vblank;
    logic vsync;
    logic hgate;
    logic vgate;
    logic vint;
  } rsg_evt_t;

  function automatic int unsigned reg_default(input int idx);
    case (idx)
      RI_HTOT: return 16;
      RI_HFP:  return 2;
      RI_HSE:  return 4;
      RI_HBW:  return 6;
      RI_VTOT: return 8;
      RI_VFP:  return 1;
      RI_VSE:  return 2;
      RI_VBW:  return 3;
      RI_VION: return 1;
      RI_VIOF: return 2;
      default: return 0;
    endcase
  endfunction

  // active for counts lo+1 .. hi
  function automatic logic in_win(input int unsigned cnt, input int unsigned lo,
                                  input int unsigned hi);
    return (cnt > lo) && (cnt <= hi);
  endfunction

  function automatic logic [3:0] route_pins(input logic [2:0] code, input rsg_evt_t e);
    logic cb;
    logic cs;
    logic cur;
    logic [3:0] p;
    cb   = e.hblank | e.vblank;
    cs   = e.hsync ^ e.vsync;
    cur  = e.hgate & e.vgate;
    p[0] = code[0] ? e.vblank : cb;
    p[1] = code[1] ? e.vsync : cs;
    p[2] = code[0] ? e.hblank : (code[2] ? cur : e.hgate);
    p[3] = code[1] ? e.hsync : (code[2] ? e.vint : e.vgate);
    return p;
  endfunction

endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
  import rsg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          commit,
  output logic [2:0]    map_code,
  output logic [3:0]    pol,
  output logic          run,
  output logic          test,
  output logic [CW-1:0] act [1:NREG-1]
);

  logic [CW-1:0] shd [1:NREG-1];
  logic          ctrl_hit;

  assign ctrl_hit = wr_en && (wr_addr == AW'(RI_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_code <= '0;
      pol      <= '0;
      run      <= 1'b1;
      test     <= 1'b0;
    end else if (ctrl_hit) begin
      map_code <= wr_data[CB_MAP +: 3];
      pol      <= wr_data[CB_POL +: 4];
      run      <= wr_data[CB_RUN];
      test     <= wr_data[CB_TEST];
    end
  end

  for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
    logic [CW-1:0] wval;
    if (gi == RI_HTOT) begin : g_even
      assign wval = {wr_data[CW-1:1], 1'b0};
    end else begin : g_plain
      assign wval = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[gi] <= CW'(reg_default(gi));
        act[gi] <= CW'(reg_default(gi));
      end else begin
        if (wr_en && (wr_addr == AW'(gi))) shd[gi] <= wval;
        if (commit) act[gi] <= shd[gi];
      end
    end
  end

endmodule

// File: rtl/rsg_count.sv
module rsg_count #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          test,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          line_end,
  output logic          frame_end
);

  logic v_step;
  logic v_last;

  assign line_end  = hcnt >= htot;
  assign v_step    = test | line_end;
  assign v_last    = vcnt >= vtot;
  assign frame_end = run & v_step & v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= CW'(1);
      vcnt <= CW'(1);
    end else if (run) begin
      hcnt <= line_end ? CW'(1) : hcnt + CW'(1);
      if (v_step) vcnt <= v_last ? CW'(1) : vcnt + CW'(1);
    end
  end

endmodule

// File: rtl/rsg_pins.sv
module rsg_pins
  import rsg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic [CW-1:0] hfp,
  input  logic [CW-1:0] hse,
  input  logic [CW-1:0] hbw,
  input  logic [CW-1:0] vfp,
  input  logic [CW-1:0] vse,
  input  logic [CW-1:0] vbw,
  input  logic [CW-1:0] vion,
  input  logic [CW-1:0] viof,
  input  logic [CW-1:0] chlo,
  input  logic [CW-1:0] chhi,
  input  logic [CW-1:0] cvlo,
  input  logic [CW-1:0] cvhi,
  input  logic [2:0]    map_code,
  input  logic [3:0]    pol,
  output rsg_evt_t      evt,
  output logic [3:0]    pins
);

  always_comb begin
    evt.hblank = in_win(32'(hcnt), 32'd0, 32'(hbw));
    evt.hsync  = in_win(32'(hcnt), 32'(hfp), 32'(hse));
    evt.vblank = in_win(32'(vcnt), 32'd0, 32'(vbw));
    evt.vsync  = in_win(32'(vcnt), 32'(vfp), 32'(vse));
    evt.hgate  = in_win(32'(hcnt), 32'(chlo), 32'(chhi));
    evt.vgate  = in_win(32'(vcnt), 32'(cvlo), 32'(cvhi));
    evt.vint   = in_win(32'(vcnt), 32'(vion), 32'(viof));
  end

  assign pins = route_pins(map_code, evt) ^ ~pol;

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int CW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [3:0]    sync_pins
);

  logic [2:0]    map_code;
  logic [3:0]    pol;
  logic          run;
  logic          test;
  logic [CW-1:0] act [1:NREG-1];
  logic [CW-1:0] hcnt;
  logic [CW-1:0] vcnt;
  logic          line_end;
  logic          frame_end;
  logic [CW-1:0] htot;
  logic [CW-1:0] vtot;
  rsg_evt_t      evt;

  assign htot = act[RI_HTOT];
  assign vtot = act[RI_VTOT];

  rsg_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .commit   (frame_end),
    .map_code (map_code),
    .pol      (pol),
    .run      (run),
    .test     (test),
    .act      (act)
  );

  rsg_count #(.CW(CW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .test      (test),
    .htot      (htot),
    .vtot      (vtot),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  rsg_pins #(.CW(CW)) u_pins (
    .hcnt     (hcnt),
    .vcnt     (vcnt),
    .hfp      (act[RI_HFP]),
    .hse      (act[RI_HSE]),
    .hbw      (act[RI_HBW]),
    .vfp      (act[RI_VFP]),
    .vse      (act[RI_VSE]),
    .vbw      (act[RI_VBW]),
    .vion     (act[RI_VION]),
    .viof     (act[RI_VIOF]),
    .chlo     (act[RI_CHLO]),
    .chhi     (act[RI_CHHI]),
    .cvlo     (act[RI_CVLO]),
    .cvhi     (act[RI_CVHI]),
    .map_code (map_code),
    .pol      (pol),
    .evt      (evt),
    .pins     (sync_pins)
  );

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          test,
  input logic          line_end,
  input logic          frame_end,
  input logic [CW-1:0] hcnt,
  input logic [CW-1:0] vcnt,
  input logic [CW-1:0] htot,
  input logic [CW-1:0] vtot
);

  AST_HCNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt != '0); // R2

  AST_HCNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run && line_end |=> hcnt == CW'(1)); // R2

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !line_end |=> hcnt == $past(hcnt) + CW'(1)); // R2

  AST_VCNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> vcnt == CW'(1)); // R2

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(hcnt) && $stable(vcnt)); // R9

  AST_TEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && test && !frame_end |=> vcnt == $past(vcnt) + CW'(1)); // R10

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(htot) && $stable(vtot)); // R8

  AST_EVEN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    htot[0] == 1'b0); // R4

endmodule

bind raster_sync_gen rsg_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .test      (test),
  .line_end  (line_end),
  .frame_end (frame_end),
  .hcnt      (hcnt),
  .vcnt      (vcnt),
  .htot      (htot),
  .vtot      (vtot)
);

// File: tb/raster_sync_gen_bench.sv
`timescale 1ns/1ps
module raster_sync_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  sync_pins;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string phase = "R1 R2 R3 default mode";

  always #4 clk = ~clk;

  raster_sync_gen u_raster_sync_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_pins(sync_pins)
  );

  // behavioural reference state
  int stage [1:14];
  int live  [1:14];
  int mctrl;
  int hc, vc;

  task automatic model_reset();
    stage = '{16, 2, 4, 6, 8, 1, 2, 3, 1, 2, 0, 0, 0, 0};
    live  = stage;
    mctrl = 1 << 10;
    hc = 1;
    vc = 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit go, tm, le, stepv, fe;
      go = mctrl[10];
      tm = mctrl[11];
      if (go) begin
        le = hc >= live[1];
        stepv = tm || le;
        fe = stepv && (vc >= live[5]);
        if (le) hc = 1; else hc = hc + 1;
        if (stepv) vc = fe ? 1 : vc + 1;
        if (fe) live = stage;
      end
      if (wr_en) begin
        if (wr_addr == 0) mctrl = int'(wr_data);
        else if (wr_addr == 1) stage[1] = int'(wr_data) & ~1;
        else if (wr_addr != 15) stage[wr_addr] = int'(wr_data);
      end
    end
  end

  function automatic bit win(int c, int lo, int hi);
    return c >= lo + 1 && c <= hi;
  endfunction

  function automatic logic [3:0] expect_pins();
    bit hb, hs, vb, vs, hg, vg, vi, cb, cs, cur;
    logic [3:0] p;
    int code;
    hb = win(hc, 0, live[4]);
    hs = win(hc, live[2], live[3]);
    vb = win(vc, 0, live[8]);
    vs = win(vc, live[6], live[7]);
    vi = win(vc, live[9], live[10]);
    hg = win(hc, live[11], live[12]);
    vg = win(vc, live[13], live[14]);
    cb = hb || vb;
    cs = hs != vs;
    cur = hg && vg;
    code = mctrl % 8;
    case (code)
      0: p = {vg, hg, cs, cb};
      1: p = {vg, hb, cs, vb};
      2: p = {hs, hg, vs, cb};
      3: p = {hs, hb, vs, vb};
      4: p = {vi, cur, cs, cb};
      5: p = {vi, hb, cs, vb};
      6: p = {hs, cur, vs, cb};
      default: p = {hs, hb, vs, vb};
    endcase
    for (int k = 0; k < 4; k++) if (!mctrl[5 + k]) p[k] = ~p[k];
    return p;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e;
      e = expect_pins();
      chk(sync_pins === e, phase, int'(sync_pins), int'(e));
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = 12'(d);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [3:0] held;
    int period;
    repeat (3) @(negedge clk);
    chk(sync_pins === 4'b1110, "R1 reset pins", int'(sync_pins), 'he);
    rst_n = 1'b1;
    #1;
    idle(300);

    // R8: stage a small mode mid-frame; it must wait for the frame end
    phase = "R8 staged interval load";
    idle(37);
    wr(1, 12); wr(2, 2); wr(3, 4); wr(4, 5);
    wr(5, 6);  wr(6, 1); wr(7, 2); wr(8, 2);
    wr(9, 3);  wr(10, 4);
    wr(11, 6); wr(12, 9); wr(13, 3); wr(14, 5);
    wr(15, 'hfff);
    idle(200);

    // R5 R6 R7: every routing code under three polarity patterns
    for (int pp = 0; pp < 3; pp++) begin
      for (int code = 0; code < 8; code++) begin
        int pv;
        pv = (pp == 0) ? 0 : ((pp == 1) ? 15 : 5);
        phase = "R3 R5 R6 R7 routing and polarity";
        wr(0, (1 << 10) | (pv << 5) | code);
        idle(80);
      end
    end

    // R4: odd line length is rounded down to even
    phase = "R4 even line length";
    wr(0, (1 << 10) | (4 << 5) | 1);
    wr(1, 11);
    idle(160);
    @(negedge clk);
    while (sync_pins[2] !== 1'b0) @(negedge clk);
    while (sync_pins[2] !== 1'b1) @(negedge clk);
    period = 0;
    do begin
      @(negedge clk);
      period++;
    end while (sync_pins[2] !== 1'b1 || period < 2);
    while (sync_pins[2] === 1'b1) begin
      @(negedge clk);
      period++;
    end
    while (sync_pins[2] !== 1'b1) begin
      @(negedge clk);
      period++;
    end
    chk(period == 10, "R4 line period", period, 10);
    #1;

    // R9: clearing the run bit freezes the timing
    phase = "R9 stopped clock";
    wr(0, (15 << 5) | 0);
    @(negedge clk);
    held = sync_pins;
    idle(25);
    @(negedge clk);
    chk(sync_pins === held, "R9 pins frozen", int'(sync_pins), int'(held));
    #1;
    wr(0, (1 << 10) | (15 << 5));
    idle(60);

    // R10: test mode steps the line count every clock
    phase = "R10 counter test mode";
    wr(0, (1 << 11) | (1 << 10) | (8 << 5) | 5);
    idle(120);
    wr(0, (1 << 10) | (2 << 5) | 3);
    idle(40);

    // R2 R8: shrink the line below the running count mid-frame
    phase = "R2 R8 mid-frame shrink";
    idle(7);
    wr(1, 4);
    idle(150);
    wr(1, 14);
    wr(5, 3);
    idle(150);
    finish_run();
  end

endmodule